// File: doc/BRIEF.md
# Serial Stuck-At Fault Simulation Engine

The engine emulates single stuck-at faults in hardware for one small, fixed combinational circuit that has five inputs and one output. The circuit is six two-input gates: G = NAND(A,B), F = NAND(B,C), H = NAND(F,D), J = NAND(D,E), K = OR(H,J), Y = AND(G,K). Every primary input, every gate output, every gate input pin and the primary output is a fault site. A fanout branch at a gate pin is a site of its own, separate from its stem. Each site can be held at 0 or at 1, which gives 24 sites and 48 faults.

Software first writes a set of test patterns into a small pattern memory. Each entry holds one input vector and the output value the fault-free circuit should produce for it. A start pulse then makes the engine walk through every fault in index order. For each fault it applies the stored patterns one per clock to a fault-free copy and a faulted copy of the circuit, and compares the two outputs. Once a pattern exposes the fault, the fault is marked detected and its remaining patterns are skipped. When the last fault has been handled, the engine pulses done. The per-fault detected bitmap and the detected count then stay unchanged until the next start. Fault coverage is the detected count divided by 48.

Top module: `fault_sim_engine`

## Requirements
- R1: A pattern vector is 5 bits with A in bit 4, B in bit 3, C in bit 2, D in bit 1 and E in bit 0. The fault-free copy computes Y = AND(NAND(A,B), OR(NAND(NAND(B,C),D), NAND(D,E))).
- R2: Fault index f = 2*site + v, where v is the stuck value and bit f of det_map belongs to fault f. The sites are numbered as follows: 0-4 are inputs A..E; 5-10 are the outputs of G, F, H, J, K and the Y gate; 11-22 are the gate pins G.A, G.B, F.B, F.C, H.F, H.D, J.D, J.E, K.H, K.J, Y.G, Y.K; 23 is the primary output.
- R3: During a run, det_map bit f is set exactly when some applied pattern makes the faulted output differ from the fault-free output. A set bit stays set until the next accepted start.
- R4: det_count always equals the number of set bits in det_map.
- R5: The engine evaluates one (fault, pattern) pair per clock. The fault index is the outer loop and the pattern address the inner loop. After a detection it moves to the next fault at once, so a run lasts the sum over faults of the patterns each one used.
- R6: done is high for exactly one cycle, in the cycle after the final evaluation. While idle, det_map and det_count hold their values.
- R7: Reset clears done, det_count, det_map and model_error. A start while idle clears the results and begins a run. A start during a run has no effect.
- R8: model_error is set when the fault-free output differs from the stored expected bit of any applied pattern. It stays set until the next accepted start.
- R9: load_en writes {load_vec, load_expect} at load_addr while idle. A load during a run is ignored.
- R10: A fault that no applied pattern exposes keeps det_map bit 0. With the 8-pattern set 01100, 01011, 00001, 00111, 00010, 01111, 11110, 10100, only faults 33 (H.D stuck at 1) and 35 (J.D stuck at 1) stay undetected, so det_count is 46.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only while idle) |
| load_en | input | 1 | Pattern memory write strobe |
| load_addr | input | PAT_AW | Pattern memory write address |
| load_vec | input | 5 | Input vector {A,B,C,D,E} |
| load_expect | input | 1 | Expected fault-free output for the vector |
| done | output | 1 | One-cycle pulse at the end of a run |
| det_count | output | 6 | Number of detected faults |
| det_map | output | 48 | Per-fault detected flags |
| model_error | output | 1 | Sticky mismatch between the fault-free copy and the stored expected bit |

## Verification
The bench goes after two redundant faults on the fanout branches of D. A design that merged the branches with their stem, or that faulted the wrong pin, would mark them detected and report 48 instead of 46. The cycle-by-cycle reference exposes an engine that keeps applying patterns after a detection or that advances the wrong loop, because its done pulse arrives on the wrong cycle. Runs with a wrong expected bit, and runs where start and loads arrive in mid-run, catch a model_error flag that is not sticky or not cleared, and catch a run that restarts or a memory that is written while busy.

// File: rtl/fsim_pkg.sv
package fsim_pkg;

    localparam int NUM_PI    = 5;
    localparam int NUM_SITE  = 24;
    localparam int NUM_FAULT = 2 * NUM_SITE;
    localparam int SITE_W    = $clog2(NUM_SITE);
    localparam int FAULT_W   = $clog2(NUM_FAULT);
    localparam int CNT_W     = $clog2(NUM_FAULT + 1);

    // Fault site numbering: inputs, gate outputs, gate pins, primary output
    typedef enum logic [SITE_W-1:0] {
        S_IN_A, S_IN_B, S_IN_C, S_IN_D, S_IN_E,
        S_G_OUT, S_F_OUT, S_H_OUT, S_J_OUT, S_K_OUT, S_Y_OUT,
        S_G_PA, S_G_PB, S_F_PB, S_F_PC, S_H_PF, S_H_PD,
        S_J_PD, S_J_PE, S_K_PH, S_K_PJ, S_Y_PG, S_Y_PK,
        S_PO
    } site_e;

    typedef struct packed {
        logic [NUM_PI-1:0] vec;
        logic              expect_bit;
    } pat_entry_t;

    typedef struct packed {
        logic [SITE_W-1:0] site;
        logic              stuck_val;
    } fault_sel_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } eng_state_e;

    function automatic fault_sel_t fault_of(input logic [FAULT_W-1:0] idx);
        fault_sel_t r;
        r.site      = idx[FAULT_W-1:1];
        r.stuck_val = idx[0];
        return r;
    endfunction

    function automatic logic inject(input logic v, input logic en, input logic sv);
        return en ? sv : v;
    endfunction

endpackage

// File: rtl/cut_netlist.sv
module cut_netlist
    import fsim_pkg::*;
(
    input  logic [NUM_PI-1:0]   pi_vec,
    input  logic [NUM_SITE-1:0] force_en,
    input  logic                force_val,
    output logic                y_out
);
    logic a, b, c, d, e;
    logic g_n, f_n, h_n, j_n, k_n, y_n;

    always_comb begin
        a = inject(pi_vec[4], force_en[S_IN_A], force_val);
        b = inject(pi_vec[3], force_en[S_IN_B], force_val);
        c = inject(pi_vec[2], force_en[S_IN_C], force_val);
        d = inject(pi_vec[1], force_en[S_IN_D], force_val);
        e = inject(pi_vec[0], force_en[S_IN_E], force_val);

        g_n = inject(~(inject(a, force_en[S_G_PA], force_val) &
                       inject(b, force_en[S_G_PB], force_val)),
                     force_en[S_G_OUT], force_val);
        f_n = inject(~(inject(b, force_en[S_F_PB], force_val) &
                       inject(c, force_en[S_F_PC], force_val)),
                     force_en[S_F_OUT], force_val);
        h_n = inject(~(inject(f_n, force_en[S_H_PF], force_val) &
                       inject(d,   force_en[S_H_PD], force_val)),
                     force_en[S_H_OUT], force_val);
        j_n = inject(~(inject(d, force_en[S_J_PD], force_val) &
                       inject(e, force_en[S_J_PE], force_val)),
                     force_en[S_J_OUT], force_val);
        k_n = inject(inject(h_n, force_en[S_K_PH], force_val) |
                     inject(j_n, force_en[S_K_PJ], force_val),
                     force_en[S_K_OUT], force_val);
        y_n = inject(inject(g_n, force_en[S_Y_PG], force_val) &
                     inject(k_n, force_en[S_Y_PK], force_val),
                     force_en[S_Y_OUT], force_val);

        y_out = inject(y_n, force_en[S_PO], force_val);
    end

endmodule

// File: rtl/fault_site_decoder.sv
module fault_site_decoder
    import fsim_pkg::*;
(
    input  logic                enable,
    input  logic [FAULT_W-1:0]  fault_idx,
    output logic [NUM_SITE-1:0] force_en,
    output logic                force_val
);
    fault_sel_t sel;

    assign sel       = fault_of(fault_idx);
    assign force_val = sel.stuck_val;

    for (genvar s = 0; s < NUM_SITE; s++) begin : g_site
        assign force_en[s] = enable && (sel.site == SITE_W'(s));
    end

endmodule

// File: rtl/pattern_store.sv
module pattern_store
    import fsim_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  pat_entry_t       wr_data,
    input  logic [AW-1:0]    rd_addr,
    output pat_entry_t       rd_data
);
    pat_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fsim_sequencer.sv
module fsim_sequencer
    import fsim_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 good_y,
    input  logic                 faulty_y,
    input  logic                 exp_bit,
    output logic                 run_active,
    output logic [FAULT_W-1:0]   fault_idx,
    output logic [AW-1:0]        pat_idx,
    output logic                 done,
    output logic [CNT_W-1:0]     det_count,
    output logic [NUM_FAULT-1:0] det_map,
    output logic                 model_error
);
    localparam logic [AW-1:0]      LAST_PAT   = AW'(DEPTH - 1);
    localparam logic [FAULT_W-1:0] LAST_FAULT = FAULT_W'(NUM_FAULT - 1);

    eng_state_e state;
    logic       hit;
    logic       advance;

    assign hit        = good_y ^ faulty_y;
    assign advance    = hit || (pat_idx == LAST_PAT);
    assign run_active = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            fault_idx   <= '0;
            pat_idx     <= '0;
            done        <= 1'b0;
            det_count   <= '0;
            det_map     <= '0;
            model_error <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_RUN;
                        fault_idx   <= '0;
                        pat_idx     <= '0;
                        det_count   <= '0;
                        det_map     <= '0;
                        model_error <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (good_y != exp_bit) begin
                        model_error <= 1'b1;
                    end
                    if (hit) begin
                        det_map[fault_idx] <= 1'b1;
                        det_count          <= det_count + 1'b1;
                    end
                    if (advance) begin
                        pat_idx <= '0;
                        if (fault_idx == LAST_FAULT) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            fault_idx <= fault_idx + 1'b1;
                        end
                    end else begin
                        pat_idx <= pat_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fault_sim_engine.sv
module fault_sim_engine
    import fsim_pkg::*;
#(
    parameter int PAT_DEPTH = 8,
    localparam int PAT_AW   = (PAT_DEPTH > 1) ? $clog2(PAT_DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 load_en,
    input  logic [PAT_AW-1:0]    load_addr,
    input  logic [NUM_PI-1:0]    load_vec,
    input  logic                 load_expect,
    output logic                 done,
    output logic [CNT_W-1:0]     det_count,
    output logic [NUM_FAULT-1:0] det_map,
    output logic                 model_error
);
    logic                run_active;
    logic [FAULT_W-1:0]  fault_idx;
    logic [PAT_AW-1:0]   pat_idx;
    pat_entry_t          wr_entry;
    pat_entry_t          cur_entry;
    logic [NUM_SITE-1:0] force_en;
    logic                force_val;
    logic                good_y;
    logic                faulty_y;

    assign wr_entry.vec        = load_vec;
    assign wr_entry.expect_bit = load_expect;

    pattern_store #(.DEPTH(PAT_DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (load_en && !run_active),
        .wr_addr (load_addr),
        .wr_data (wr_entry),
        .rd_addr (pat_idx),
        .rd_data (cur_entry)
    );

    fault_site_decoder u_dec (
        .enable    (run_active),
        .fault_idx (fault_idx),
        .force_en  (force_en),
        .force_val (force_val)
    );

    cut_netlist u_good (
        .pi_vec    (cur_entry.vec),
        .force_en  ('0),
        .force_val (1'b0),
        .y_out     (good_y)
    );

    cut_netlist u_faulty (
        .pi_vec    (cur_entry.vec),
        .force_en  (force_en),
        .force_val (force_val),
        .y_out     (faulty_y)
    );

    fsim_sequencer #(.DEPTH(PAT_DEPTH)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .good_y      (good_y),
        .faulty_y    (faulty_y),
        .exp_bit     (cur_entry.expect_bit),
        .run_active  (run_active),
        .fault_idx   (fault_idx),
        .pat_idx     (pat_idx),
        .done        (done),
        .det_count   (det_count),
        .det_map     (det_map),
        .model_error (model_error)
    );

endmodule

// File: rtl/fault_sim_engine_chk.sv
module fault_sim_engine_chk
    import fsim_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 run_active,
    input logic                 done,
    input logic [CNT_W-1:0]     det_count,
    input logic [NUM_FAULT-1:0] det_map,
    input logic                 model_error
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!run_active && $past(run_active))); // R6

    AST_COUNT_EQ_MAP: assert property (@(posedge clk) disable iff (rst)
        det_count == CNT_W'($countones(det_map))); // R4

    AST_MAP_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((det_map & $past(det_map)) == $past(det_map))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run_active && !start) |=> ($stable(det_map) && $stable(det_count))); // R6

    AST_MERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (model_error && !start) |=> model_error); // R8

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start && !run_active) |=> (run_active && det_count == '0 && !model_error)); // R7

endmodule

bind fault_sim_engine fault_sim_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .run_active  (run_active),
    .done        (done),
    .det_count   (det_count),
    .det_map     (det_map),
    .model_error (model_error)
);

// File: tb/fault_sim_engine_bench.sv
`timescale 1ns/1ps
module fault_sim_engine_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int NF    = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [4:0]    load_vec = '0;
    logic          load_expect = 1'b0;
    logic          done;
    logic [5:0]    det_count;
    logic [NF-1:0] det_map;
    logic          model_error;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fault_sim_engine #(.PAT_DEPTH(DEPTH)) u_fault_sim_engine (
        .clk(clk), .rst(rst), .start(start), .load_en(load_en),
        .load_addr(load_addr), .load_vec(load_vec), .load_expect(load_expect),
        .done(done), .det_count(det_count), .det_map(det_map),
        .model_error(model_error)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic pk(logic x, int id, int site, logic sv);
        return (id == site) ? sv : x;
    endfunction

    // site numbering per R2; site -1 means fault-free
    function automatic logic ref_eval(logic [4:0] v, int site, logic sv);
        logic a, b, c, d, e, g, f, h, j, k, y;
        a = pk(v[4], 0, site, sv);
        b = pk(v[3], 1, site, sv);
        c = pk(v[2], 2, site, sv);
        d = pk(v[1], 3, site, sv);
        e = pk(v[0], 4, site, sv);
        g = pk(!(pk(a, 11, site, sv) && pk(b, 12, site, sv)), 5, site, sv);
        f = pk(!(pk(b, 13, site, sv) && pk(c, 14, site, sv)), 6, site, sv);
        h = pk(!(pk(f, 15, site, sv) && pk(d, 16, site, sv)), 7, site, sv);
        j = pk(!(pk(d, 17, site, sv) && pk(e, 18, site, sv)), 8, site, sv);
        k = pk(pk(h, 19, site, sv) || pk(j, 20, site, sv), 9, site, sv);
        y = pk(pk(g, 21, site, sv) && pk(k, 22, site, sv), 10, site, sv);
        return pk(y, 23, site, sv);
    endfunction

    logic [4:0]    rm_vec [DEPTH];
    logic          rm_exp [DEPTH];
    bit            rm_run = 0;
    int            rm_f = 0, rm_p = 0, rm_evals = 0;
    logic [NF-1:0] rm_map = '0;
    int            rm_cnt = 0;
    logic          rm_done = 0, rm_merr = 0;
    bit            live = 0;

    always @(posedge clk) begin
        bit  was_run;
        logic gy, fy;
        was_run = rm_run;
        if (rst) begin
            rm_run = 0; rm_map = '0; rm_cnt = 0; rm_done = 0; rm_merr = 0;
        end else begin
            rm_done = 0;
            if (rm_run) begin
                gy = ref_eval(rm_vec[rm_p], -1, 1'b0);
                fy = ref_eval(rm_vec[rm_p], rm_f / 2, rm_f[0]);
                rm_evals++;
                if (gy != rm_exp[rm_p]) rm_merr = 1;
                if (gy != fy) begin
                    rm_map[rm_f] = 1'b1; rm_cnt++;
                end
                if (gy != fy || rm_p == DEPTH - 1) begin
                    rm_p = 0;
                    if (rm_f == NF - 1) begin rm_run = 0; rm_done = 1; end
                    else rm_f++;
                end else rm_p++;
            end else if (start) begin
                rm_run = 1; rm_f = 0; rm_p = 0; rm_evals = 0;
                rm_map = '0; rm_cnt = 0; rm_merr = 0;
            end
            if (load_en && !was_run) begin
                rm_vec[load_addr] = load_vec;
                rm_exp[load_addr] = load_expect;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (done !== rm_done) begin
                errors++; $display("FAIL R6 done: got %0b expected %0b", done, rm_done);
            end
            checks++;
            if (det_map !== rm_map) begin
                errors++; $display("FAIL R3 det_map: got %h expected %h", det_map, rm_map);
            end
            checks++;
            if (det_count !== 6'(rm_cnt)) begin
                errors++; $display("FAIL R4 det_count: got %0d expected %0d", det_count, rm_cnt);
            end
            checks++;
            if (model_error !== rm_merr) begin
                errors++; $display("FAIL R8 model_error: got %0b expected %0b", model_error, rm_merr);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic load_one(int addr, logic [4:0] v, logic e);
        @(negedge clk);
        load_en = 1; load_addr = AW'(addr); load_vec = v; load_expect = e;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic load_set(logic [4:0] vs [DEPTH], int bad_at);
        for (int i = 0; i < DEPTH; i++) begin
            logic ex;
            ex = ref_eval(vs[i], -1, 1'b0);
            if (i == bad_at) ex = ~ex;
            load_one(i, vs[i], ex);
        end
    endtask

    task automatic run_wait(output int cyc);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        logic [4:0]    set_doc [DEPTH];
        logic [4:0]    set_zero [DEPTH];
        logic [4:0]    set_mix [DEPTH];
        logic [NF-1:0] keep_map;
        int            cyc;

        set_doc = '{5'b01100, 5'b01011, 5'b00001, 5'b00111,
                    5'b00010, 5'b01111, 5'b11110, 5'b10100};
        for (int i = 0; i < DEPTH; i++) begin
            set_zero[i] = 5'b00000;
            set_mix[i]  = 5'((i * 5 + 3) % 32);
        end

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        live = 1;
        // R7: reset state
        check("R7 reset done", 64'(done), 0);
        check("R7 reset count", 64'(det_count), 0);
        check("R7 reset map", 64'(det_map), 0);
        check("R7 reset model_error", 64'(model_error), 0);

        // R1 R2 R10: stored set with correct expected bits
        load_set(set_doc, -1);
        run_wait(cyc);
        check("R5 run length doc set", 64'(cyc), 64'(rm_evals + 1));
        check("R10 detected count 46", 64'(det_count), 46);
        check("R10 faults 33/35 undetected, rest detected (R2 indexing)",
              64'(det_map), 64'(~((48'd1 << 33) | (48'd1 << 35)) & {NF{1'b1}}));
        check("R1 fault-free copy matches expected bits", 64'(model_error), 0);
        keep_map = det_map;
        repeat (4) @(negedge clk);
        check("R6 results held while idle", 64'(det_map), 64'(keep_map));

        // R8: one wrong expected bit
        load_set(set_doc, 3);
        run_wait(cyc);
        check("R8 model_error raised", 64'(model_error), 1);
        check("R3 map unaffected by expected bit", 64'(det_map), 64'(keep_map));
        load_one(3, set_doc[3], ref_eval(set_doc[3], -1, 1'b0));
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check("R8 model_error cleared at start", 64'(model_error), 0);
        while (!done) @(negedge clk);

        // R5: all-zero patterns: little detection, long run
        load_set(set_zero, -1);
        run_wait(cyc);
        check("R5 run length zero set", 64'(cyc), 64'(rm_evals + 1));
        check("R3 zero set count", 64'(det_count), 64'(rm_cnt));

        // R7 R9: start and load during a run are ignored
        load_set(set_mix, -1);
        run_wait(cyc);
        keep_map = det_map;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        start = 1; load_en = 1; load_addr = 0; load_vec = 5'b11111; load_expect = 1'b0;
        @(negedge clk);
        start = 0; load_en = 0;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        check("R7 mid-run start ignored", 64'(det_map), 64'(keep_map));
        run_wait(cyc);
        check("R9 mid-run load ignored", 64'(det_map), 64'(keep_map));
        check("R9 mid-run load kept expected bits", 64'(model_error), 0);

        repeat (3) @(negedge clk);
        finish_sim();
    end

endmodule